// File: doc/BRIEF.md
# Capture-Compare Auto-Reload Timer

This block is a 16-bit up-counter driven by a programmable prescaler. One 16-bit shared register serves three roles: it holds the value reloaded into the counter, it receives the counter value when a capture strobe arrives, and it holds the value the counter is compared against. A mode input selects between two modes of operation.

In reload mode the counter can be reloaded from the shared register. The trigger is either a counter overflow or one of three capture strobes. Any capture strobe copies the counter into the shared register, and an optional capture-clear option sets the counter to zero at the same time. In compare mode the capture strobes are ignored. When the counter equals the shared register on a count tick, a sticky match flag is set, and an optional compare-clear option sets the counter to zero. A sticky overflow flag is set whenever the counter passes FFFFh. Software loads the shared register through a simple write port and clears either flag by writing a 1 to its clear bit.

Top module: `tmr_ccr_top`

## Requirements
- R1: With `run_en` high, the counter advances once every N clocks, where N is 1, 4, 16, 32, 64, 128, 256 or 512 for `psc_sel` codes 0 through 7. The first advance comes on the Nth rising edge after `run_en` rises. While `run_en` is low, the prescaler is held at its start, so a pause restarts the division.
- R2: In reload mode (`mode_cmp`=0) with `reload_en`=1 and `trig_sel`=0, a count tick taken at FFFFh loads the shared register value into the counter.
- R3: In reload mode with `reload_en`=1 and `trig_sel`=k (k=1,2,3), a strobe on `cap_stb[k-1]` loads the counter with the shared register value held before that edge. A strobe on any other capture input does not reload the counter.
- R4: In reload mode, a strobe on any capture input copies the counter value into the shared register on that same clock edge, whatever the tick timing. If a capture and a software write fall in the same cycle, the capture is kept.
- R5: In reload mode with `cap_clr_en`=1, a capture strobe sets the counter to 0000h on that edge, and this takes priority over a reload. With `cap_clr_en`=0, the counter keeps its normal behaviour.
- R6: In compare mode (`mode_cmp`=1), a count tick taken while the counter equals the shared register sets `cmp_flag`. The counter then goes to 0000h if `cmp_clr_en`=1, and to the counter value plus one otherwise.
- R7: A count tick at FFFFh sets `ovf_flag`. If no reload applies, the counter wraps to 0000h.
- R8: Both flags stay set until software clears them. Bit 0 of `flag_clr` clears `ovf_flag` and bit 1 clears `cmp_flag`. A new event in the same cycle as a clear wins, and the flag stays set.
- R9: Reset clears the counter, the shared register and both flags.
- R10: In compare mode, capture strobes change neither the shared register nor the counter, and `cap_clr_en` has no effect.
- R11: With `reload_en`=0, no event reloads the counter, but captures still copy the counter into the shared register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Enables counting and the prescaler |
| mode_cmp | input | 1 | 0 = reload mode, 1 = compare mode |
| reload_en | input | 1 | Enables counter reload in reload mode |
| psc_sel | input | 3 | Prescale code |
| trig_sel | input | 2 | Reload trigger: 0 overflow, k = capture input k-1 |
| cap_clr_en | input | 1 | Clear counter on capture (reload mode) |
| cmp_clr_en | input | 1 | Clear counter on match (compare mode) |
| cap_stb | input | 3 | Single-cycle capture strobes |
| wr_en | input | 1 | Write strobe for the shared register |
| wr_data | input | 16 | Write data for the shared register |
| flag_clr | input | 2 | Write-1-to-clear: bit 0 overflow, bit 1 match |
| count | output | 16 | Counter value |
| shadow | output | 16 | Shared reload/capture/compare register |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare-match flag |

## Verification
Captures are sampled on every clock, while counting happens only on prescaled ticks. A capture can therefore land on the same edge as a count increment, or on the same edge as a software write to the shared register. The bench strobes a non-selected capture input while the counter runs at divide-by-one. It then expects the register to hold the pre-edge count while the counter still moves on by one. It also raises a write and a capture together and expects the captured count, not the written data. A third collision, capture-clear against a capture-triggered reload, is judged by requiring a zero count and a captured register.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic {
    MODE_RELOAD = 1'b0,
    MODE_CMP    = 1'b1
  } tmr_mode_e;

  // log2 of the prescale divisor for each 3-bit code
  function automatic int unsigned psc_shift(input logic [2:0] code);
    case (code)
      3'd0:    psc_shift = 0;
      3'd1:    psc_shift = 2;
      default: psc_shift = 32'(code) + 2;
    endcase
  endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PSC_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic [2:0] psc_sel,
  output logic       tick
);
  import tmr_pkg::*;

  logic [PSC_W-1:0] pcnt_q, pcnt_d, lim;

  assign lim  = (PSC_W'(1) << psc_shift(psc_sel)) - PSC_W'(1);
  assign tick = run_en && (pcnt_q >= lim);

  always_comb begin
    if (!run_en || tick) pcnt_d = '0;
    else                 pcnt_d = pcnt_q + PSC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/tmr_shared_reg.sv
module tmr_shared_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_evt,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] reg_q
);
  logic [CNT_W-1:0] reg_d;
  logic             reg_ce;

  assign reg_ce = cap_evt || wr_en;

  always_comb begin
    if (cap_evt) reg_d = cnt_q;
    else         reg_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_q <= '0;
    else if (reg_ce) reg_q <= reg_d;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             mode_cmp,
  input  logic             reload_en,
  input  logic             trig_ovf,
  input  logic             cap_any,
  input  logic             cap_hit,
  input  logic             cap_clr_en,
  input  logic             cmp_clr_en,
  input  logic [CNT_W-1:0] reg_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_evt,
  output logic             cmp_evt
);
  import tmr_pkg::*;

  logic [CNT_W-1:0] cnt_d;
  logic             at_max, reload_mode;

  assign reload_mode = (mode_cmp == MODE_RELOAD);
  assign at_max      = &cnt_q;
  assign ovf_evt     = tick && at_max;
  assign cmp_evt     = tick && !reload_mode && (cnt_q == reg_q);

  always_comb begin
    cnt_d = cnt_q;
    if (reload_mode && cap_any && cap_clr_en) begin
      cnt_d = '0;
    end else if (reload_mode && reload_en && cap_hit) begin
      cnt_d = reg_q;
    end else if (tick) begin
      if (cmp_evt && cmp_clr_en)
        cnt_d = '0;
      else if (at_max)
        cnt_d = (reload_mode && reload_en && trig_ovf) ? reg_q : '0;
      else
        cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tmr_ccr_top.sv
module tmr_ccr_top #(
  parameter  int CNT_W = 16,
  parameter  int PSC_W = 10,
  parameter  int N_CAP = 3,
  localparam int TRG_W = $clog2(N_CAP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             mode_cmp,
  input  logic             reload_en,
  input  logic [2:0]       psc_sel,
  input  logic [TRG_W-1:0] trig_sel,
  input  logic             cap_clr_en,
  input  logic             cmp_clr_en,
  input  logic [N_CAP-1:0] cap_stb,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       flag_clr,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] shadow,
  output logic             ovf_flag,
  output logic             cmp_flag
);
  import tmr_pkg::*;

  logic             tick, cap_any, cap_hit, ovf_evt, cmp_evt;
  logic [N_CAP-1:0] hit_v;
  logic [1:0]       flg_q, flg_d, flg_set;

  assign cap_any = (mode_cmp == MODE_RELOAD) && (|cap_stb);

  for (genvar i = 0; i < N_CAP; i++) begin : g_hit
    assign hit_v[i] = cap_stb[i] && (trig_sel == TRG_W'(i + 1));
  end
  assign cap_hit = |hit_v;

  tmr_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .psc_sel(psc_sel), .tick(tick)
  );

  tmr_shared_reg #(.CNT_W(CNT_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .cap_evt(cap_any), .wr_en(wr_en),
    .wr_data(wr_data), .cnt_q(count), .reg_q(shadow)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_cmp(mode_cmp),
    .reload_en(reload_en), .trig_ovf(trig_sel == '0), .cap_any(cap_any),
    .cap_hit(cap_hit), .cap_clr_en(cap_clr_en), .cmp_clr_en(cmp_clr_en),
    .reg_q(shadow), .cnt_q(count), .ovf_evt(ovf_evt), .cmp_evt(cmp_evt)
  );

  // sticky flags: set wins over a software clear
  assign flg_set = {cmp_evt, ovf_evt};

  for (genvar f = 0; f < 2; f++) begin : g_flg
    always_comb begin
      if (flg_set[f])      flg_d[f] = 1'b1;
      else if (flag_clr[f]) flg_d[f] = 1'b0;
      else                 flg_d[f] = flg_q[f];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  assign ovf_flag = flg_q[0];
  assign cmp_flag = flg_q[1];
endmodule

// File: rtl/tmr_ccr_chk.sv
module tmr_ccr_chk #(
  parameter int CNT_W = 16,
  parameter int N_CAP = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             mode_cmp,
  input logic             cap_clr_en,
  input logic [N_CAP-1:0] cap_stb,
  input logic             wr_en,
  input logic [1:0]       flag_clr,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] shadow,
  input logic             ovf_flag,
  input logic             cmp_flag,
  input logic             tick
);
  AST_CAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_cmp && |cap_stb) |=> shadow == $past(count)); // R4
  AST_CAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_cmp && |cap_stb && cap_clr_en) |=> count == '0); // R5
  AST_OVF_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(tick) && $past(&count))); // R7
  AST_CMP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_flag) |-> ($past(mode_cmp) && $past(count) == $past(shadow))); // R6
  AST_OVF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[0] && !(tick && &count)) |=> !ovf_flag); // R8
  AST_CMP_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cmp && !wr_en) |=> $stable(shadow)); // R10
  AST_CMP_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cmp && !run_en) |=> $stable(count)); // R1
endmodule

bind tmr_ccr_top tmr_ccr_chk #(.CNT_W(CNT_W), .N_CAP(N_CAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode_cmp(mode_cmp),
  .cap_clr_en(cap_clr_en), .cap_stb(cap_stb), .wr_en(wr_en),
  .flag_clr(flag_clr), .count(count), .shadow(shadow),
  .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .tick(tick)
);

// File: tb/sim_tmr_ccr_top.sv
module sim_tmr_ccr_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        run_en, mode_cmp, reload_en, cap_clr_en, cmp_clr_en, wr_en;
  logic [2:0]  psc_sel;
  logic [1:0]  trig_sel;
  logic [2:0]  cap_stb;
  logic [15:0] wr_data;
  logic [1:0]  flag_clr;
  logic [15:0] count, shadow;
  logic        ovf_flag, cmp_flag;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  tmr_ccr_top u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode_cmp(mode_cmp),
    .reload_en(reload_en), .psc_sel(psc_sel), .trig_sel(trig_sel),
    .cap_clr_en(cap_clr_en), .cmp_clr_en(cmp_clr_en), .cap_stb(cap_stb),
    .wr_en(wr_en), .wr_data(wr_data), .flag_clr(flag_clr),
    .count(count), .shadow(shadow), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  typedef struct packed {
    logic [2:0]  psc;
    logic [15:0] ncyc;
    logic [15:0] exp_cnt;
  } vec_t;

  // expected count = floor(cycles / divisor)
  localparam vec_t VECS [8] = '{
    '{3'd0, 16'd10,   16'd10},
    '{3'd1, 16'd11,   16'd2},
    '{3'd2, 16'd40,   16'd2},
    '{3'd3, 16'd100,  16'd3},
    '{3'd4, 16'd130,  16'd2},
    '{3'd5, 16'd300,  16'd2},
    '{3'd6, 16'd600,  16'd2},
    '{3'd7, 16'd1100, 16'd2}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic defaults();
    run_en = 0; mode_cmp = 0; reload_en = 0; psc_sel = 0; trig_sel = 0;
    cap_clr_en = 0; cmp_clr_en = 0; cap_stb = 0; wr_en = 0; wr_data = 0;
    flag_clr = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    defaults();
    cyc(2);
    rst_n = 1;
    cyc(1);
  endtask

  task automatic wr_reg(input logic [15:0] v);
    wr_en = 1; wr_data = v;
    cyc(1);
    wr_en = 0;
  endtask

  task automatic strobe(input int idx);
    cap_stb = 3'(1 << idx);
    cyc(1);
    cap_stb = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] c;
    rst_n = 0;
    defaults();
    cyc(2);
    chk("R9 count", 32'(count), 0);
    chk("R9 shadow", 32'(shadow), 0);
    chk("R9 flags", {30'd0, cmp_flag, ovf_flag}, 0);
    rst_n = 1;
    cyc(1);

    // R1 prescale table
    foreach (VECS[i]) begin
      do_reset();
      psc_sel = VECS[i].psc;
      run_en = 1;
      cyc(int'(VECS[i].ncyc));
      chk($sformatf("R1 psc%0d", VECS[i].psc), 32'(count), 32'(VECS[i].exp_cnt));
    end

    // R1 pause restarts the prescaler
    do_reset();
    psc_sel = 1; run_en = 1; cyc(3);
    run_en = 0; cyc(1);
    run_en = 1; cyc(3);
    chk("R1 restart", 32'(count), 0);
    cyc(1);
    chk("R1 restart tick", 32'(count), 1);

    // R3 reload from capture 0, stopped counter
    do_reset();
    reload_en = 1; trig_sel = 1;
    wr_reg(16'hFFFD);
    strobe(0);
    chk("R3 cap0 reload", 32'(count), 32'hFFFD);
    chk("R4 cap0 copy", 32'(shadow), 0);

    // R2 overflow reload, R7 flag
    wr_reg(16'h1234);
    trig_sel = 0; run_en = 1;
    cyc(3);
    run_en = 0;
    chk("R2 ovf reload", 32'(count), 32'h1234);
    chk("R7 ovf flag", 32'(ovf_flag), 1);
    flag_clr = 2'b01; cyc(1); flag_clr = 0;
    chk("R8 ovf clear", 32'(ovf_flag), 0);

    // R7 wrap without reload
    trig_sel = 1;
    wr_reg(16'hFFFD);
    strobe(0);
    reload_en = 0; trig_sel = 0; run_en = 1;
    cyc(3);
    run_en = 0;
    chk("R7 wrap", 32'(count), 0);
    chk("R7 wrap flag", 32'(ovf_flag), 1);

    // R11 no reload, capture still copies
    run_en = 1; cyc(5); run_en = 0;
    trig_sel = 1;
    wr_reg(16'h7777);
    strobe(0);
    chk("R11 count kept", 32'(count), 5);
    chk("R11 captured", 32'(shadow), 5);

    // R4 capture during counting; R3 unselected input does not reload
    reload_en = 1; trig_sel = 1; run_en = 1;
    cyc(4);
    c = count;
    cap_stb = 3'b100;
    cyc(1);
    cap_stb = 0; run_en = 0;
    chk("R4 capture on tick", 32'(shadow), 32'(c));
    chk("R3 unselected counts", 32'(count), 32'(c + 16'd1));

    // R4 capture beats write
    c = count;
    trig_sel = 2;
    wr_en = 1; wr_data = 16'hAAAA; cap_stb = 3'b001;
    cyc(1);
    wr_en = 0; cap_stb = 0;
    chk("R4 capture over write", 32'(shadow), 32'(c));
    chk("R3 unselected no reload", 32'(count), 32'(c));

    // R3 each selectable capture input
    for (int k = 1; k <= 3; k++) begin
      c = count;
      trig_sel = 2'(k);
      wr_reg(16'(16'h1100 * k));
      strobe(k - 1);
      chk($sformatf("R3 trig%0d count", k), 32'(count), 32'(16'h1100 * k));
      chk($sformatf("R3 trig%0d shadow", k), 32'(shadow), 32'(c));
    end

    // R5 capture clear wins over reload
    c = count;
    cap_clr_en = 1; trig_sel = 1;
    wr_reg(16'h4321);
    strobe(0);
    cap_clr_en = 0;
    chk("R5 cleared", 32'(count), 0);
    chk("R5 captured", 32'(shadow), 32'(c));

    // R6 compare with clear
    do_reset();
    mode_cmp = 1;
    wr_reg(16'd5);
    cmp_clr_en = 1; run_en = 1;
    cyc(6);
    run_en = 0;
    chk("R6 match clear", 32'(count), 0);
    chk("R6 cmp flag", 32'(cmp_flag), 1);
    chk("R6 no ovf", 32'(ovf_flag), 0);

    cmp_clr_en = 0;
    flag_clr = 2'b10; cyc(1); flag_clr = 0;
    chk("R8 cmp clear", 32'(cmp_flag), 0);
    run_en = 1;
    cyc(6);
    run_en = 0;
    chk("R6 match continue", 32'(count), 6);
    chk("R6 cmp flag again", 32'(cmp_flag), 1);

    // R10 capture ignored in compare mode
    cap_clr_en = 1; reload_en = 1; trig_sel = 1;
    strobe(0);
    cap_clr_en = 0;
    chk("R10 count kept", 32'(count), 6);
    chk("R10 shadow kept", 32'(shadow), 5);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule